// File: doc/BRIEF.md
# Multi-Mode 4:2:2 Video Input Deinterleaver

This block takes YCbCr 4:2:2 video that arrives byte-interleaved on an 8-bit pixel bus and rebuilds it as parallel luma and chroma samples, with a one-cycle valid strobe per sample. A 3-bit format selector picks one of three bus formats. Two are single-rate, with one byte per clock: standard definition, and enhanced definition at a doubled clock. The third is double-data-rate, where one byte arrives on each clock edge. The double-data-rate capture is modelled as two byte lanes that have already been registered, one lane for the rising edge and one for the falling edge. A 2-bit field chooses which of the two lanes carries luma.

Line and frame timing comes from timing reference codes embedded in the byte stream. These are an all-ones byte, two all-zeros bytes, then a status byte. The block decodes them into horizontal blanking, vertical blanking and field flags, and it checks the protection bits of the status byte. In the standard-definition and double-data-rate formats, external horizontal and vertical sync pins can be used as the timing source instead. A new format or edge selection is taken up only at the next valid timing reference. The sample phase restarts at that same point.

Top module: `vid422_deint`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `smp_valid`, `field` and `prot_err` are 0, and `hblank` and `vblank` are 1. The applied format is standard definition (000) and the applied edge selection is 00.
- R2: In single-rate formats, `lane_rise` carries one byte per clock in the repeating order Cb, Y, Cr, Y. `lane_fall` is not used. Each Y byte gives one sample: `smp_valid` is 1 in the cycle after that byte is presented. `y_out` holds the Y byte. `c_out` holds the Cb byte (`c_is_cr`=0) for the first Y of the group and the Cr byte (`c_is_cr`=1) for the second.
- R3: Format 111 uses the same single-rate byte order as R2. In format 111, `use_ext_sync`, `ext_hsync` and `ext_vsync` have no effect, and timing comes only from embedded codes.
- R4: In format 010 (double data rate), luma is read from `lane_fall` and chroma from `lane_rise` when the applied edge selection is 11. For any other edge selection, luma is read from `lane_rise` and chroma from `lane_fall`.
- R5: In format 010, every clock inside an active line gives one sample in the next cycle. The chroma of the first sample after a start code is Cb (`c_is_cr`=0), and the chroma type then alternates on every sample.
- R6: A timing reference is the byte sequence FF, 00, 00, S. In single-rate formats these are four consecutive bytes. In double-data-rate format, one clock carries luma FF and chroma 00, and the next clock carries luma 00 and chroma S. In the status byte S, bit 6 is the field, bit 5 is vertical blanking, and bit 4 is 1 for end-of-active-video (sets `hblank`) or 0 for start-of-active-video (clears `hblank`). The flags update in the cycle after S.
- R7: `smp_valid` is 1 only inside a line, which runs from a start code to the next end code. With embedded timing, an all-ones byte on the luma or single-rate path ends the line at once and is never output.
- R8: A status byte is accepted only if bit 7 is 1 and bits 3:0 are equal to {V^H, F^H, F^V, F^V^H}. A rejected code pulses `prot_err` for one cycle. It leaves the flags, the line state and the applied format and edge selection unchanged.
- R9: Changes to `mode_sel` and `luma_edge_sel` are applied only at the next accepted timing reference, and the sample phase restarts at that point.
- R10: In formats 000 and 010 with `use_ext_sync`=1, `hblank` and `vblank` follow `ext_hsync` and `ext_vsync` one cycle later. The line is active in the cycle after both pins are low. `field` is still taken from accepted codes.
- R11: Format codes other than 010 and 111 behave as standard definition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Requested bus format (000, 010, 111) |
| luma_edge_sel | input | 2 | Requested luma lane for double data rate (11 = falling lane) |
| use_ext_sync | input | 1 | Take timing from the sync pins where the format allows it |
| ext_hsync | input | 1 | External horizontal sync, high during blanking |
| ext_vsync | input | 1 | External vertical sync, high during blanking |
| lane_rise | input | 8 | Byte captured on the rising clock edge |
| lane_fall | input | 8 | Byte captured on the falling clock edge |
| y_out | output | 8 | Reassembled luma sample |
| c_out | output | 8 | Chroma sample paired with `y_out` |
| c_is_cr | output | 1 | 1 when `c_out` is Cr, 0 when it is Cb |
| smp_valid | output | 1 | One-cycle strobe for each output sample |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| field | output | 1 | Field flag |
| prot_err | output | 1 | One-cycle pulse on a rejected status byte |

## Verification
Some properties are checked by assertions on every cycle. A single-rate sample strobe is never followed by another in the next cycle. Back-to-back double-data-rate samples alternate Cb and Cr. An active line never coexists with horizontal blanking. A rejected status byte leaves every timing flag unchanged. The applied format changes only after an accepted reference. A detected reference is always preceded by FF, 00, 00 on the byte path. Other behaviour can only be shown by the directed scenarios: the exact byte-to-sample pairing and latency, lane swapping by edge selection, deferral of a format change to the next code, the sync pins being ignored in the doubled-clock format, and unknown format codes falling back to standard definition.

// File: rtl/vdi_pkg.sv
package vdi_pkg;
   localparam int VDI_MODE_W = 3;
   localparam logic [VDI_MODE_W-1:0] VDI_MODE_SD   = 3'b000;
   localparam logic [VDI_MODE_W-1:0] VDI_MODE_DDR  = 3'b010;
   localparam logic [VDI_MODE_W-1:0] VDI_MODE_ED2X = 3'b111;

   // expected protection nibble for a status byte
   function automatic logic [3:0] vdi_prot(input logic f, input logic v, input logic h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction
endpackage

// File: rtl/vdi_lane_sel.sv
module vdi_lane_sel #(
   parameter int DATA_W = 8,
   parameter int EDGE_W = 2
) (
   input  logic [EDGE_W-1:0] edge_sel,
   input  logic              single_rate,
   input  logic [DATA_W-1:0] lane_rise,
   input  logic [DATA_W-1:0] lane_fall,
   output logic [DATA_W-1:0] prim,
   output logic [DATA_W-1:0] sec
);
   logic luma_on_fall;

   assign luma_on_fall = (&edge_sel) && !single_rate;

   always_comb begin
      if (luma_on_fall) begin
         prim = lane_fall;
         sec  = lane_rise;
      end else begin
         prim = lane_rise;
         sec  = lane_fall;
      end
   end
endmodule

// File: rtl/vdi_trs_det.sv
module vdi_trs_det #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_ddr,
   input  logic [DATA_W-1:0] prim,
   input  logic [DATA_W-1:0] sec,
   output logic              hit,
   output logic [DATA_W-1:0] xy
);
   localparam int          HIST_D = 3;
   localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] ZERO = {DATA_W{1'b0}};

   logic [DATA_W-1:0] hist [HIST_D];
   logic [DATA_W-1:0] sec_q;
   logic              match_sr, match_ddr;

   assign match_sr  = (hist[2] == ONES) && (hist[1] == ZERO) && (hist[0] == ZERO);
   assign match_ddr = (hist[0] == ONES) && (sec_q == ZERO) && (prim == ZERO);
   assign hit       = is_ddr ? match_ddr : match_sr;
   assign xy        = is_ddr ? sec : prim;

   always_ff @(posedge clk) begin
      if (!rst_n || hit) begin
         hist[0] <= ZERO;
         sec_q   <= ZERO;
      end else begin
         hist[0] <= prim;
         sec_q   <= sec;
      end
   end

   generate
      for (genvar gi = 1; gi < HIST_D; gi++) begin : g_hist
         always_ff @(posedge clk) begin
            if (!rst_n || hit) hist[gi] <= ZERO;
            else               hist[gi] <= hist[gi-1];
         end
      end
   endgenerate

   // R6
   sr_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !is_ddr) |-> ($past(prim) == ZERO && $past(prim, 2) == ZERO && $past(prim, 3) == ONES));
endmodule

// File: rtl/vdi_timing.sv
module vdi_timing (
   input  logic clk,
   input  logic rst_n,
   input  logic apply,
   input  logic reject,
   input  logic code_f,
   input  logic code_v,
   input  logic code_h,
   input  logic ext_act,
   input  logic ext_hs,
   input  logic ext_vs,
   input  logic pre_start,
   output logic hblank,
   output logic vblank,
   output logic field,
   output logic in_line,
   output logic prot_err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hblank   <= 1'b1;
         vblank   <= 1'b1;
         field    <= 1'b0;
         in_line  <= 1'b0;
         prot_err <= 1'b0;
      end else begin
         prot_err <= reject;
         if (apply) field <= code_f;
         if (ext_act) begin
            hblank  <= ext_hs;
            vblank  <= ext_vs;
            in_line <= !ext_hs && !ext_vs;
         end else if (apply) begin
            hblank  <= code_h;
            vblank  <= code_v;
            in_line <= !code_h;
         end else if (pre_start) begin
            in_line <= 1'b0;
         end
      end
   end

   // R7
   inline_nohblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_line |-> !hblank);

   // R8
   prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_err && !$past(ext_act)) |->
         ($stable(hblank) && $stable(vblank) && $stable(field) && $stable(in_line)));
endmodule

// File: rtl/vdi_sample_asm.sv
module vdi_sample_asm #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_ddr,
   input  logic              in_line,
   input  logic              suppress,
   input  logic              phase_clr,
   input  logic [DATA_W-1:0] prim,
   input  logic [DATA_W-1:0] sec,
   output logic [DATA_W-1:0] y_out,
   output logic [DATA_W-1:0] c_out,
   output logic              c_is_cr,
   output logic              smp_valid
);
   localparam int PH_W = 2;

   logic [PH_W-1:0]   phase;
   logic [DATA_W-1:0] c_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= '0;
         c_hold    <= '0;
         y_out     <= '0;
         c_out     <= '0;
         c_is_cr   <= 1'b0;
         smp_valid <= 1'b0;
      end else begin
         smp_valid <= 1'b0;
         if (phase_clr || !in_line) begin
            phase <= '0;
         end else if (!suppress) begin
            phase <= phase + 1'b1;
            if (is_ddr) begin
               y_out     <= prim;
               c_out     <= sec;
               c_is_cr   <= phase[0];
               smp_valid <= 1'b1;
            end else if (!phase[0]) begin
               c_hold <= prim;
            end else begin
               y_out     <= prim;
               c_out     <= c_hold;
               c_is_cr   <= phase[1];
               smp_valid <= 1'b1;
            end
         end
      end
   end

   // R2
   sr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !is_ddr) |=> !smp_valid);

   // R5
   ddr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && $past(smp_valid) && $past(is_ddr)) |-> (c_is_cr != $past(c_is_cr)));
endmodule

// File: rtl/vid422_deint.sv
module vid422_deint #(
   parameter int DATA_W      = 8,
   parameter int MODE_W      = 3,
   parameter int EDGE_W      = 2,
   parameter bit EXT_SYNC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [EDGE_W-1:0] luma_edge_sel,
   input  logic              use_ext_sync,
   input  logic              ext_hsync,
   input  logic              ext_vsync,
   input  logic [DATA_W-1:0] lane_rise,
   input  logic [DATA_W-1:0] lane_fall,
   output logic [DATA_W-1:0] y_out,
   output logic [DATA_W-1:0] c_out,
   output logic              c_is_cr,
   output logic              smp_valid,
   output logic              hblank,
   output logic              vblank,
   output logic              field,
   output logic              prot_err
);
   import vdi_pkg::*;

   localparam int MRK_BIT = DATA_W - 1;
   localparam int F_BIT   = DATA_W - 2;
   localparam int V_BIT   = DATA_W - 3;
   localparam int H_BIT   = DATA_W - 4;
   localparam int P_HI    = DATA_W - 5;
   localparam int P_LO    = DATA_W - 8;
   localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (MODE_W == VDI_MODE_W) else $error("MODE_W must match the package");
      assert (EDGE_W >= 1) else $error("EDGE_W must be positive");
   end

   logic [MODE_W-1:0] mode_q;
   logic [EDGE_W-1:0] edge_q;
   logic              is_ddr, is_ed2x, ext_act;
   logic [DATA_W-1:0] prim, sec, xy;
   logic              hit, code_ok, apply, reject, pre_start, in_line;

   assign is_ddr  = (mode_q == VDI_MODE_DDR);
   assign is_ed2x = (mode_q == VDI_MODE_ED2X);

   generate
      if (EXT_SYNC_EN) begin : g_ext
         assign ext_act = use_ext_sync && !is_ed2x;
      end else begin : g_noext
         assign ext_act = use_ext_sync && 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= VDI_MODE_SD;
         edge_q <= '0;
      end else if (apply) begin
         mode_q <= mode_sel;
         edge_q <= luma_edge_sel;
      end
   end

   vdi_lane_sel #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) i_lane_sel (
      .edge_sel    (edge_q),
      .single_rate (!is_ddr),
      .lane_rise   (lane_rise),
      .lane_fall   (lane_fall),
      .prim        (prim),
      .sec         (sec)
   );

   vdi_trs_det #(.DATA_W(DATA_W)) i_trs_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .is_ddr (is_ddr),
      .prim   (prim),
      .sec    (sec),
      .hit    (hit),
      .xy     (xy)
   );

   assign code_ok   = xy[MRK_BIT] && (xy[P_HI:P_LO] == vdi_prot(xy[F_BIT], xy[V_BIT], xy[H_BIT]));
   assign apply     = hit && code_ok;
   assign reject    = hit && !code_ok;
   assign pre_start = (prim == ONES);

   vdi_timing i_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (apply),
      .reject    (reject),
      .code_f    (xy[F_BIT]),
      .code_v    (xy[V_BIT]),
      .code_h    (xy[H_BIT]),
      .ext_act   (ext_act),
      .ext_hs    (ext_hsync),
      .ext_vs    (ext_vsync),
      .pre_start (pre_start),
      .hblank    (hblank),
      .vblank    (vblank),
      .field     (field),
      .in_line   (in_line),
      .prot_err  (prot_err)
   );

   vdi_sample_asm #(.DATA_W(DATA_W)) i_sample_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_ddr    (is_ddr),
      .in_line   (in_line),
      .suppress  (pre_start && !ext_act),
      .phase_clr (apply),
      .prim      (prim),
      .sec       (sec),
      .y_out     (y_out),
      .c_out     (c_out),
      .c_is_cr   (c_is_cr),
      .smp_valid (smp_valid)
   );

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mode_q) || !$stable(edge_q)) |-> $past(apply));
endmodule

// File: tb/test_vid422_deint.sv
module test_vid422_deint;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_sel = 3'b000;
   logic [1:0] luma_edge_sel = 2'b00;
   logic       use_ext_sync = 1'b0;
   logic       ext_hsync = 1'b0;
   logic       ext_vsync = 1'b0;
   logic [7:0] lane_rise = 8'h10;
   logic [7:0] lane_fall = 8'h10;
   logic [7:0] y_out, c_out;
   logic       c_is_cr, smp_valid, hblank, vblank, field, prot_err;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;
   logic swap = 1'b0;
   logic [7:0] cap_y [64];
   logic [7:0] cap_c [64];
   logic       cap_cr [64];
   int cap_n = 0;

   always #10 clk = ~clk;

   vid422_deint i_vid422_deint (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .luma_edge_sel(luma_edge_sel),
      .use_ext_sync(use_ext_sync), .ext_hsync(ext_hsync), .ext_vsync(ext_vsync),
      .lane_rise(lane_rise), .lane_fall(lane_fall), .y_out(y_out), .c_out(c_out),
      .c_is_cr(c_is_cr), .smp_valid(smp_valid), .hblank(hblank), .vblank(vblank),
      .field(field), .prot_err(prot_err)
   );

   function automatic logic [7:0] mkxy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, look after the rising edge
   task automatic put(input logic [7:0] r, input logic [7:0] f);
      @(negedge clk);
      lane_rise = r;
      lane_fall = f;
      @(posedge clk);
      #1;
      if (smp_valid && cap_n < 64) begin
         cap_y[cap_n] = y_out;
         cap_c[cap_n] = c_out;
         cap_cr[cap_n] = c_is_cr;
         cap_n++;
      end
   endtask

   task automatic put_sr(input logic [7:0] b);
      put(b, 8'h10);
   endtask

   task automatic put_ddr(input logic [7:0] l, input logic [7:0] c);
      if (swap) put(c, l);
      else      put(l, c);
   endtask

   task automatic trs_sr(input logic [7:0] s);
      put_sr(8'hFF); put_sr(8'h00); put_sr(8'h00); put_sr(s);
   endtask

   task automatic trs_ddr(input logic [7:0] s);
      put_ddr(8'hFF, 8'h00); put_ddr(8'h00, s);
   endtask

   task automatic chk_cap(input string tag, input int idx, input logic [7:0] y,
                          input logic [7:0] c, input logic cr);
      chk({tag, " y"}, cap_y[idx], y);
      chk({tag, " c"}, cap_c[idx], c);
      chk({tag, " cr"}, cap_cr[idx], cr);
   endtask

   task automatic t_reset;
      put_sr(8'h10);
      chk("R1 valid in reset", smp_valid, 0);
      chk("R1 hblank in reset", hblank, 1);
      chk("R1 vblank in reset", vblank, 1);
      chk("R1 field in reset", field, 0);
      chk("R1 prot_err in reset", prot_err, 0);
      @(negedge clk);
      rst_n = 1'b1;
      put_sr(8'h10);
      chk("R1 valid after release", smp_valid, 0);
      chk("R1 hblank after release", hblank, 1);
   endtask

   task automatic t_sd;
      int base;
      trs_sr(mkxy(0, 0, 0));
      chk("R6 SAV clears hblank", hblank, 0);
      chk("R6 SAV vblank", vblank, 0);
      base = cap_n;
      put_sr(8'h40);
      chk("R2 no sample on Cb", smp_valid, 0);
      put_sr(8'h51);
      chk("R2 sample after Y", smp_valid, 1);
      put_sr(8'h62); put_sr(8'h53);
      put_sr(8'h44); put_sr(8'h55); put_sr(8'h66); put_sr(8'h57);
      trs_sr(mkxy(0, 0, 1));
      chk("R6 EAV sets hblank", hblank, 1);
      chk("R7 sample count over line", cap_n - base, 4);
      chk_cap("R2 s0", base,     8'h51, 8'h40, 0);
      chk_cap("R2 s1", base + 1, 8'h53, 8'h62, 1);
      chk_cap("R2 s2", base + 2, 8'h55, 8'h44, 0);
      chk_cap("R2 s3", base + 3, 8'h57, 8'h66, 1);
   endtask

   task automatic t_code_prot;
      int base;
      trs_sr(mkxy(1, 1, 1));
      chk("R6 field bit6", field, 1);
      chk("R6 vblank bit5", vblank, 1);
      chk("R6 EAV hblank", hblank, 1);
      base = cap_n;
      trs_sr(mkxy(0, 0, 0) ^ 8'h01);
      chk("R8 prot_err pulse", prot_err, 1);
      chk("R8 hblank held", hblank, 1);
      chk("R8 field held", field, 1);
      put_sr(8'h40);
      chk("R8 prot_err one cycle", prot_err, 0);
      put_sr(8'h51); put_sr(8'h62); put_sr(8'h53);
      chk("R8 R7 no samples after rejected code", cap_n - base, 0);
      trs_sr(mkxy(0, 0, 0));
      chk("R6 field cleared", field, 0);
      chk("R6 vblank cleared", vblank, 0);
      trs_sr(mkxy(0, 0, 1));
   endtask

   task automatic t_mode_ddr;
      int base;
      trs_sr(mkxy(0, 0, 0));
      mode_sel = 3'b010;
      base = cap_n;
      put_sr(8'h41); put_sr(8'h52); put_sr(8'h63); put_sr(8'h54);
      chk("R9 still single-rate before code", cap_n - base, 2);
      chk_cap("R9 deferred s1", base + 1, 8'h54, 8'h63, 1);
      trs_sr(mkxy(0, 0, 1));
      trs_ddr(mkxy(0, 0, 0));
      chk("R6 DDR SAV", hblank, 0);
      base = cap_n;
      put_ddr(8'h21, 8'h31);
      chk("R5 sample each clock", smp_valid, 1);
      put_ddr(8'h22, 8'h32); put_ddr(8'h23, 8'h33);
      luma_edge_sel = 2'b11;
      put_ddr(8'h24, 8'h34);
      chk("R5 DDR count", cap_n - base, 4);
      chk_cap("R5 d0", base,     8'h21, 8'h31, 0);
      chk_cap("R5 d1", base + 1, 8'h22, 8'h32, 1);
      chk_cap("R4 d2", base + 2, 8'h23, 8'h33, 0);
      chk_cap("R9 edge deferred d3", base + 3, 8'h24, 8'h34, 1);
      trs_ddr(mkxy(0, 0, 1));
      chk("R7 DDR EAV", hblank, 1);
      swap = 1'b1;
      trs_ddr(mkxy(0, 0, 0));
      base = cap_n;
      put_ddr(8'h25, 8'h35); put_ddr(8'h26, 8'h36);
      chk("R4 swapped count", cap_n - base, 2);
      chk_cap("R4 swapped e0", base,     8'h25, 8'h35, 0);
      chk_cap("R4 swapped e1", base + 1, 8'h26, 8'h36, 1);
   endtask

   task automatic t_ed2x;
      int base;
      mode_sel = 3'b111;
      trs_ddr(mkxy(0, 0, 1));
      swap = 1'b0;
      use_ext_sync = 1'b1;
      ext_hsync = 1'b1;
      ext_vsync = 1'b1;
      trs_sr(mkxy(0, 0, 0));
      chk("R3 pins ignored hblank", hblank, 0);
      chk("R3 pins ignored vblank", vblank, 0);
      base = cap_n;
      put_sr(8'h47); put_sr(8'h58); put_sr(8'h69); put_sr(8'h5A);
      chk("R3 sample count", cap_n - base, 2);
      chk_cap("R3 s0", base,     8'h58, 8'h47, 0);
      chk_cap("R3 s1", base + 1, 8'h5A, 8'h69, 1);
      mode_sel = 3'b000;
      trs_sr(mkxy(0, 0, 1));
   endtask

   task automatic t_ext;
      int base;
      ext_hsync = 1'b1;
      ext_vsync = 1'b0;
      put_sr(8'h10);
      chk("R10 hblank follows pin", hblank, 1);
      chk("R10 vblank follows pin", vblank, 0);
      ext_hsync = 1'b0;
      base = cap_n;
      put_sr(8'h10);
      chk("R10 hblank released", hblank, 0);
      put_sr(8'h48); put_sr(8'h59); put_sr(8'h6A); put_sr(8'h5B);
      chk("R10 sample count", cap_n - base, 2);
      chk_cap("R10 s0", base,     8'h59, 8'h48, 0);
      chk_cap("R10 s1", base + 1, 8'h5B, 8'h6A, 1);
      ext_hsync = 1'b1;
      put_sr(8'h10);
      chk("R10 hblank raised", hblank, 1);
      use_ext_sync = 1'b0;
      ext_hsync = 1'b0;
   endtask

   task automatic t_badmode;
      int base;
      mode_sel = 3'b011;
      trs_sr(mkxy(0, 0, 1));
      trs_sr(mkxy(0, 0, 0));
      chk("R11 SAV seen single-rate", hblank, 0);
      base = cap_n;
      put_sr(8'h4C); put_sr(8'h5D); put_sr(8'h6E); put_sr(8'h5F);
      chk("R11 single-rate count", cap_n - base, 2);
      chk_cap("R11 s1", base + 1, 8'h5F, 8'h6E, 1);
      trs_sr(mkxy(0, 0, 1));
   endtask

   initial begin
      t_reset();
      t_sd();
      t_code_prot();
      t_mode_ddr();
      t_ed2x();
      t_ext();
      t_badmode();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule